// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block reads a telephone-style keypad of twelve switches arranged as three column lines and four row lines. A switch, when closed, connects its column line to its row line. The scanner drives the columns, samples the rows through a two-flop synchronizing and debouncing stage, and works out which single key is held. It then reports a 4-bit key code together with a one-cycle valid strobe.

While no key is held, all columns are driven high and the scanner waits for any row to read high. It then drives one column at a time, starting at column 0, until a row answers. After reporting the key, it drives all columns high again and waits for every row to go low before it accepts a new press. Each press therefore produces exactly one strobe. The clock is meant to run slower than the switch bounce time, so that the two-flop stage settles on clean values.

Top module: `keypad_scan`

## Requirements
- R1: A synchronous active-high reset sets `col_drv` to 3'b111, `key_valid` low and `key_code` to 4'b0000.
- R2: While idle, `col_drv` stays at 3'b111 until a debounced row reads 1. A row reaches the debounced value two clocks after it is sampled.
- R3: After a press is seen, `col_drv` bit c drives column c. The scan drives 3'b001, then 3'b010, then 3'b100. Each column is held for three cycles, and the decision uses rows sampled only after that column was driven.
- R4: `key_valid` is high for exactly one cycle when a key is found, and `key_code` holds the key's code in that cycle.
- R5: From the strobe cycle on, `col_drv` is 3'b111 until the debounced rows are all 0. No further strobe occurs while the key stays held, so each press gives one strobe.
- R6: `row_in` bit r is row r. The rows hold the keys 1,2,3 / 4,5,6 / 7,8,9 / *,0,#, listed by column 0 to 2. Digits are coded in binary, * as 4'b1010 and # as 4'b1011.
- R7: If no row answers during all three column tests, the scanner returns to idle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow scan clock, period longer than switch bounce |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | 4 | Raw row lines, bit r is row r |
| col_drv | output | 3 | Column drive, bit c is column c |
| key_code | output | 4 | Code of the last key found |
| key_valid | output | 1 | One-cycle strobe when a key is found |

## Verification
The assertions check the following on every cycle:
- the column drive is always all-high or a single column;
- after column 0, the drive moves only to column 1 or back to all-high;
- a strobe lasts one cycle, comes from a single-column test, and falls while all columns are high;
- a reported code is always in range.

Only the bench's scenarios can show the rest: the correct code for each of the twelve keys, a single strobe across a long hold, and a short glitch that ends without a strobe. The bench shows these with a behavioural keypad and scanner model compared with the outputs every clock.

// File: rtl/keypad_scan.sv
module keypad_scan (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] row_in,
  output logic [2:0] col_drv,
  output logic [3:0] key_code,
  output logic       key_valid
);
  localparam int NCOL   = 3;
  localparam int SETTLE = 2;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_HOLD} st_t;

  st_t        st;
  logic [3:0] row_s1, row_db;
  logic [1:0] col_idx, cnt;
  logic [1:0] row_idx;
  logic [3:0] hit_code;
  logic       any_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_s1 <= '0;
      row_db <= '0;
    end else begin
      row_s1 <= row_in;
      row_db <= row_s1;
    end
  end

  assign any_row = |row_db;
  assign col_drv = (st == S_SCAN) ? 3'(3'b001 << col_idx) : 3'b111;

  always_comb begin
    row_idx = 2'd0;
    for (int r = 3; r >= 0; r--)
      if (row_db[r]) row_idx = 2'(r);
  end

  always_comb begin
    if (row_idx != 2'd3) hit_code = 4'(row_idx) * 4'd3 + 4'(col_idx) + 4'd1;
    else case (col_idx)
      2'd0:    hit_code = 4'b1010;
      2'd1:    hit_code = 4'b0000;
      default: hit_code = 4'b1011;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      col_idx   <= '0;
      cnt       <= '0;
      key_code  <= '0;
      key_valid <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      case (st)
        S_IDLE: if (any_row) begin
          st      <= S_SCAN;
          col_idx <= '0;
          cnt     <= '0;
        end
        S_SCAN: begin
          if (cnt != 2'(SETTLE)) cnt <= cnt + 2'd1;
          else if (any_row) begin
            key_valid <= 1'b1;
            key_code  <= hit_code;
            st        <= S_HOLD;
          end else if (col_idx == 2'(NCOL - 1)) st <= S_IDLE;
          else begin
            col_idx <= col_idx + 2'd1;
            cnt     <= '0;
          end
        end
        S_HOLD: if (!any_row) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module keypad_scan_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] row_in,
  input logic [2:0] col_drv,
  input logic [3:0] key_code,
  input logic       key_valid
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (col_drv == 3'b111 && !key_valid && key_code == 4'b0000));

  a_r3_drive_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(col_drv) == 1 || col_drv == 3'b111));

  a_r3_after_c0: assert property (@(posedge clk) disable iff (rst)
    ($past(col_drv) == 3'b001 && col_drv != 3'b001) |-> (col_drv == 3'b010 || col_drv == 3'b111));

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  a_r4_from_column: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $countones($past(col_drv)) == 1);

  a_r5_hold_all_high: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> col_drv == 3'b111);

  a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> key_code <= 4'd11);

  logic unused_rows;
  assign unused_rows = ^row_in;
endmodule

bind keypad_scan keypad_scan_chk u_chk (.*);

// File: tb/keypad_scan_tb.sv
module keypad_scan_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in;
  logic [2:0] col_drv;
  logic [3:0] key_code;
  logic       key_valid;

  int  pressed = -1;
  int  n_cmp = 0, n_bad = 0;
  int  pulses = 0;
  int  last_code = -1;
  bit  done = 0;

  keypad_scan u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] rows_for(int k, logic [2:0] cols);
    if (k < 0) return 4'b0;
    return cols[k % 3] ? 4'(1 << (k / 3)) : 4'b0;
  endfunction

  assign row_in = rows_for(pressed, col_drv);

  function automatic int code_of(int k);
    int tbl[12] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 0, 11};
    return tbl[k];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 scanning, 2 waiting for release
  int m_state = 0, m_col = 0, m_wait = 0;
  logic [3:0] m_s1 = 0, m_db = 0;
  logic [2:0] m_cols = 3'b111;
  logic       m_valid = 0;
  logic [3:0] m_code = 0;

  always @(posedge clk) begin
    logic [3:0] now_rows, db_old;
    now_rows = rows_for(pressed, m_cols);
    db_old = m_db;
    if (rst) begin
      m_s1 = 0; m_db = 0; m_state = 0; m_col = 0; m_wait = 0;
      m_valid = 0; m_code = 0;
    end else begin
      m_db = m_s1;
      m_s1 = now_rows;
      m_valid = 0;
      if (m_state == 0) begin
        if (db_old != 0) begin m_state = 1; m_col = 0; m_wait = 0; end
      end else if (m_state == 1) begin
        if (m_wait < 2) m_wait++;
        else if (db_old != 0) begin
          int r;
          r = 0;
          while (!db_old[r]) r++;
          m_valid = 1;
          m_code = 4'(code_of(r * 3 + m_col));
          m_state = 2;
        end else if (m_col == 2) m_state = 0;
        else begin m_col++; m_wait = 0; end
      end else if (db_old == 0) m_state = 0;
    end
    m_cols = (m_state == 1) ? 3'(1 << m_col) : 3'b111;
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(col_drv == m_cols, "R3 col_drv", col_drv, m_cols);
      check(key_valid == m_valid, "R4 key_valid", key_valid, m_valid);
      check(key_code == m_code, "R6 key_code", key_code, m_code);
      if (key_valid) begin pulses++; last_code = key_code; end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    check(col_drv == 3'b111, "R1 reset col_drv", col_drv, 7);
    check(key_valid == 1'b0, "R1 reset key_valid", key_valid, 0);
    check(key_code == 4'b0, "R1 reset key_code", key_code, 0);
    rst = 1'b0;
    idle(6);
    check(col_drv == 3'b111, "R2 idle drive", col_drv, 7);
    check(pulses == 0, "R2 no strobe idle", pulses, 0);
    for (int k = 0; k < 12; k++) begin
      pulses = 0;
      pressed = k;
      idle(30);
      pressed = -1;
      idle(8);
      check(pulses == 1, "R5 one strobe per press", pulses, 1);
      check(last_code == code_of(k), "R6 code map", last_code, code_of(k));
    end
    pulses = 0;
    pressed = 7;
    idle(2);
    pressed = -1;
    idle(20);
    check(pulses == 0, "R7 glitch no strobe", pulses, 0);
    check(col_drv == 3'b111, "R7 back to idle", col_drv, 7);
    pulses = 0;
    pressed = 11;
    idle(60);
    check(pulses == 1, "R5 long hold single strobe", pulses, 1);
    pressed = -1;
    idle(8);
    rst = 1'b1;
    idle(2);
    check(col_drv == 3'b111 && key_code == 0 && !key_valid, "R1 reset again", key_code, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule